// File: doc/BRIEF.md
# Training Pattern Generator and Lane Checker

This block supports read-timing calibration of a memory channel. A fill command writes a fixed 40-entry test pattern into one or two ranks. The pattern goes out over a simple request/response word port. A later check command reads the pattern back and says whether a single byte lane returned every expected byte. The fill is a separate command from the check, so the region is written once and can then be checked many times, once per lane and per delay setting tried by an outside controller.

The pattern is laid out with an 8-byte stride. Each entry occupies two consecutive 32-bit words. A lane index of 0 to 7 selects which half of each 8-byte pair is read and which byte of that word is compared. One lane is therefore judged only on its own byte positions. A check stops at the first masked mismatch. Completion is signalled by a one-cycle done pulse with the pass flag valid alongside it.

Top module: `trn_lane_probe`

## Requirements
- R1: After reset `busy`, `done`, `pass` and `mem_req` are all low.
- R2: A fill command issues 80 word writes per rank, in rank order 0 then 1. Write k of a rank goes to byte address base + 4k (k = 0..79, ascending) and carries pattern entry k/2 (integer division).
- R3: Pattern entry i is one byte repeated in all four bytes of the word. For i in 0..7 the byte is 0xFF with bit i cleared. For i in 8..15 it is 0x80 shifted right by i-8. For i in 16..31 it is 0x10 when i is even and 0xEF when odd. For i in 32..39 it is 0x00 when i is even and 0xFF when odd.
- R4: A check command for lane L issues 40 reads per rank, in rank order. Read j goes to base + 8j + 4 when bit 2 of L is set, and to base + 8j otherwise (j = 0..39, ascending).
- R5: A check compares only byte number L mod 4 of each read word, meaning bits 8·(L mod 4)+7 down to 8·(L mod 4), against the same byte of pattern entry j. All other read-data bits have no effect on the result.
- R6: When every compared byte of every checked rank matches, the command ends with `done` high and `pass` high in the same cycle.
- R7: When `dual_rank` is 0 at command start, only rank 0 is written or checked. When it is 1, rank 0 and then rank 1 are handled.
- R8: On the first masked mismatch no further read is issued, and the command ends with `done` high and `pass` low.
- R9: `done` is high for exactly one cycle per command, and `busy` stays high from the cycle after the start until that cycle. Start inputs arriving while `busy` is high are ignored.
- R10: The lane, rank count and both base addresses are captured when a command starts. Bits 2:0 of each base are treated as zero.
- R11: If `fill_go` and `check_go` are high together while idle, only the fill runs, and it ends with `pass` high.
- R12: A request holds its address, direction and data until `mem_rdy` is high. After an accepted read, no new request is issued until `mem_rvalid` returns the data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fill_go | input | 1 | Start pulse for a pattern fill |
| check_go | input | 1 | Start pulse for a lane check |
| lane | input | 3 | Byte lane to check |
| dual_rank | input | 1 | 1 selects two ranks, 0 selects one |
| rank0_base | input | 32 | Byte base address of rank 0 |
| rank1_base | input | 32 | Byte base address of rank 1 |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Request byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdy | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Result, valid while `done` is high |

## Verification
The properties assume a well-behaved memory side. `mem_rvalid` rises only once per accepted read and never without a pending one, and `mem_rdy` may stall a request for any number of cycles. The bench's memory model answers each accepted read exactly once, with a latency of one or two cycles, and holds `mem_rdy` low on a repeating subset of cycles. It keeps `lane`, `dual_rank` and both bases unchanged while a command runs. Start pulses delivered during a command are deliberate and exercise the ignore rule.

// File: rtl/trn_pkg.sv
package trn_pkg;

    localparam int unsigned TRN_RANKS = 2;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_WR    = 3'd1,
        ST_RD    = 3'd2,
        ST_RWAIT = 3'd3,
        ST_FIN   = 3'd4
    } trn_state_e;

    typedef enum logic {
        OP_FILL  = 1'b0,
        OP_CHECK = 1'b1
    } trn_op_e;

    typedef struct packed {
        trn_op_e    op;
        logic [2:0] lane;
        logic       dual;
    } trn_cmd_t;

    // One byte per pattern entry; the word repeats it in every byte.
    function automatic logic [7:0] trn_pattern_byte(input int unsigned idx);
        logic [7:0] b;
        if (idx < 8)
            b = ~(8'h01 << idx[2:0]);
        else if (idx < 16)
            b = 8'h80 >> idx[2:0];
        else if (idx < 32)
            b = idx[0] ? 8'hEF : 8'h10;
        else
            b = idx[0] ? 8'hFF : 8'h00;
        return b;
    endfunction

endpackage

// File: rtl/trn_pattern_src.sv
module trn_pattern_src #(
    parameter int unsigned WORDS  = 40,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IDX_W  = 6
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [DATA_W-1:0] word
);
    import trn_pkg::*;

    localparam int unsigned BYTES = DATA_W / 8;

    logic [7:0] pat_byte;

    always_comb begin
        if (int'(idx) < int'(WORDS))
            pat_byte = trn_pattern_byte(int'(idx));
        else
            pat_byte = 8'h00;
    end

    for (genvar g = 0; g < BYTES; g++) begin : g_rep
        assign word[g*8 +: 8] = pat_byte;
    end

endmodule

// File: rtl/trn_lane_cmp.sv
module trn_lane_cmp #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned BSEL_W = 2
) (
    input  logic [BSEL_W-1:0] byte_sel,
    input  logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] expect_w,
    output logic              match
);
    localparam int unsigned BYTES = DATA_W / 8;

    logic [DATA_W-1:0] mask;

    for (genvar g = 0; g < BYTES; g++) begin : g_mask
        assign mask[g*8 +: 8] = {8{byte_sel == BSEL_W'(g)}};
    end

    assign match = ((rdata ^ expect_w) & mask) == '0;

endmodule

// File: rtl/trn_seq.sv
module trn_seq #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned WORDS  = 40,
    parameter int unsigned LANE_W = 3,
    parameter int unsigned IDX_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fill_go,
    input  logic              check_go,
    input  logic [LANE_W-1:0] lane,
    input  logic              dual_rank,
    input  logic [ADDR_W-1:0] base0,
    input  logic [ADDR_W-1:0] base1,
    input  logic              mem_rdy,
    input  logic              mem_rvalid,
    input  logic              byte_ok,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [IDX_W-1:0]  pat_idx,
    output logic [LANE_W-2:0] byte_sel,
    output logic              busy,
    output logic              done,
    output logic              pass
);
    import trn_pkg::*;

    localparam int unsigned SLOTS = 2 * WORDS;
    localparam int unsigned CNT_W = $clog2(SLOTS);
    localparam int unsigned ALIGN = 3;

    trn_state_e        state;
    trn_op_e           op_q;
    logic [LANE_W-1:0] lane_q;
    logic              dual_q;
    logic              rank_q;
    logic [CNT_W-1:0]  cnt;
    logic              pass_q;
    logic [ADDR_W-1:0] base0_q;
    logic [ADDR_W-1:0] base1_q;

    logic [ADDR_W-1:0] rank_base;
    logic [ADDR_W-1:0] offset;
    logic              last_slot;
    logic              last_rank;

    function automatic logic [ADDR_W-1:0] align_base(input logic [ADDR_W-1:0] a);
        return {a[ADDR_W-1:ALIGN], {ALIGN{1'b0}}};
    endfunction

    assign rank_base = rank_q ? base1_q : base0_q;

    always_comb begin
        if (op_q == OP_FILL) begin
            offset    = ADDR_W'(cnt) << 2;
            pat_idx   = IDX_W'(cnt >> 1);
            last_slot = cnt == CNT_W'(SLOTS - 1);
        end else begin
            offset    = (ADDR_W'(cnt) << 3) | (lane_q[LANE_W-1] ? ADDR_W'(4) : '0);
            pat_idx   = IDX_W'(cnt);
            last_slot = cnt == CNT_W'(WORDS - 1);
        end
    end

    assign last_rank = (rank_q == dual_q);
    assign mem_addr  = rank_base + offset;
    assign mem_req   = (state == ST_WR) || (state == ST_RD);
    assign mem_we    = (state == ST_WR);
    assign busy      = (state != ST_IDLE);
    assign done      = (state == ST_FIN);
    assign pass      = pass_q;
    assign byte_sel  = lane_q[LANE_W-2:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            op_q    <= OP_FILL;
            lane_q  <= '0;
            dual_q  <= 1'b0;
            rank_q  <= 1'b0;
            cnt     <= '0;
            pass_q  <= 1'b0;
            base0_q <= '0;
            base1_q <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (fill_go || check_go) begin
                        op_q    <= fill_go ? OP_FILL : OP_CHECK;
                        state   <= fill_go ? ST_WR : ST_RD;
                        lane_q  <= lane;
                        dual_q  <= dual_rank;
                        base0_q <= align_base(base0);
                        base1_q <= align_base(base1);
                        rank_q  <= 1'b0;
                        cnt     <= '0;
                    end
                end
                ST_WR: begin
                    if (mem_rdy) begin
                        if (!last_slot) begin
                            cnt <= cnt + 1'b1;
                        end else if (!last_rank) begin
                            rank_q <= 1'b1;
                            cnt    <= '0;
                        end else begin
                            pass_q <= 1'b1;
                            state  <= ST_FIN;
                        end
                    end
                end
                ST_RD: begin
                    if (mem_rdy)
                        state <= ST_RWAIT;
                end
                ST_RWAIT: begin
                    if (mem_rvalid) begin
                        if (!byte_ok) begin
                            pass_q <= 1'b0;
                            state  <= ST_FIN;
                        end else if (!last_slot) begin
                            cnt   <= cnt + 1'b1;
                            state <= ST_RD;
                        end else if (!last_rank) begin
                            rank_q <= 1'b1;
                            cnt    <= '0;
                            state  <= ST_RD;
                        end else begin
                            pass_q <= 1'b1;
                            state  <= ST_FIN;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/trn_lane_probe.sv
module trn_lane_probe #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned WORDS  = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fill_go,
    input  logic              check_go,
    input  logic [2:0]        lane,
    input  logic              dual_rank,
    input  logic [ADDR_W-1:0] rank0_base,
    input  logic [ADDR_W-1:0] rank1_base,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_rdy,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              busy,
    output logic              done,
    output logic              pass
);
    localparam int unsigned BYTES  = DATA_W / 8;
    localparam int unsigned BSEL_W = $clog2(BYTES);
    localparam int unsigned LANE_W = BSEL_W + 1;
    localparam int unsigned IDX_W  = $clog2(WORDS);

    logic [IDX_W-1:0]  pat_idx;
    logic [DATA_W-1:0] pat_word;
    logic [BSEL_W-1:0] byte_sel;
    logic              byte_ok;

    trn_seq #(
        .ADDR_W(ADDR_W), .WORDS(WORDS), .LANE_W(LANE_W), .IDX_W(IDX_W)
    ) u_seq (
        .clk(clk), .rst(rst), .fill_go(fill_go), .check_go(check_go),
        .lane(lane[LANE_W-1:0]), .dual_rank(dual_rank),
        .base0(rank0_base), .base1(rank1_base),
        .mem_rdy(mem_rdy), .mem_rvalid(mem_rvalid), .byte_ok(byte_ok),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .pat_idx(pat_idx), .byte_sel(byte_sel),
        .busy(busy), .done(done), .pass(pass)
    );

    trn_pattern_src #(
        .WORDS(WORDS), .DATA_W(DATA_W), .IDX_W(IDX_W)
    ) u_pat (
        .idx(pat_idx), .word(pat_word)
    );

    trn_lane_cmp #(
        .DATA_W(DATA_W), .BSEL_W(BSEL_W)
    ) u_cmp (
        .byte_sel(byte_sel), .rdata(mem_rdata), .expect_w(pat_word), .match(byte_ok)
    );

    assign mem_wdata = pat_word;

endmodule

module trn_lane_probe_chk #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_rdy,
    input logic              mem_rvalid,
    input logic              busy,
    input logic              done
);
    logic rd_pending;

    always_ff @(posedge clk) begin
        if (rst)
            rd_pending <= 1'b0;
        else if (mem_req && !mem_we && mem_rdy)
            rd_pending <= 1'b1;
        else if (mem_rvalid)
            rd_pending <= 1'b0;
    end

    // R9: done lasts one cycle and returns the block to idle
    p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));

    // R9: once busy, stays busy until done
    p_busy_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);

    // R12: stalled request keeps its content
    p_req_stable_r12: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr) &&
                                   $stable(mem_we) && $stable(mem_wdata)));

    // R12: no request while a read is outstanding
    p_one_read_r12: assert property (@(posedge clk) disable iff (rst)
        rd_pending |-> !mem_req);

    // R2: word-aligned addresses
    p_word_align_r2: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    // R1: requests only inside an active command
    p_req_in_cmd_r1: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (busy && !done));

endmodule

bind trn_lane_probe trn_lane_probe_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdy(mem_rdy),
    .mem_rvalid(mem_rvalid), .busy(busy), .done(done)
);

// File: tb/test_trn_lane_probe.sv
module test_trn_lane_probe;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fill_go = 1'b0;
    logic        check_go = 1'b0;
    logic [2:0]  lane = 3'd0;
    logic        dual_rank = 1'b0;
    logic [31:0] rank0_base = '0;
    logic [31:0] rank1_base = '0;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_rdy = 1'b0;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        busy;
    logic        done;
    logic        pass;

    always #4 clk = ~clk;

    trn_lane_probe i_trn_lane_probe (
        .clk(clk), .rst(rst), .fill_go(fill_go), .check_go(check_go),
        .lane(lane), .dual_rank(dual_rank),
        .rank0_base(rank0_base), .rank1_base(rank1_base),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdy(mem_rdy), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .busy(busy), .done(done), .pass(pass)
    );

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;

    bit [31:0] mem [bit [31:0]];
    bit [31:0] q_addr[$];
    bit        q_we[$];
    bit [31:0] q_data[$];

    int  tick = 0;
    int  rsp_wait = 0;
    bit [31:0] rsp_addr = 0;
    bit  in_cmd = 0;
    int  done_cnt = 0;
    bit  last_pass = 0;

    function automatic bit [31:0] ref_pat(input int i);
        bit [7:0] b;
        if (i < 8)       b = 8'hFF ^ (8'd1 << i);
        else if (i < 16) b = 8'h80 >> (i - 8);
        else if (i < 32) b = (i % 2 == 1) ? 8'hEF : 8'h10;
        else             b = (i % 2 == 1) ? 8'hFF : 8'h00;
        return {b, b, b, b};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // memory model and per-clock comparison, away from the active edge
    always @(negedge clk) begin
        tick++;
        mem_rvalid = 1'b0;
        if (rsp_wait > 0) begin
            rsp_wait--;
            if (rsp_wait == 0) begin
                mem_rvalid = 1'b1;
                mem_rdata  = mem.exists(rsp_addr) ? mem[rsp_addr] : 32'h0;
            end
        end
        mem_rdy = !rst && (tick % 5 != 3);
        if (!rst) begin
            if (!in_cmd)
                check(!busy && !mem_req && !done, "R9", "idle outputs",
                      {busy, mem_req, done}, 0);
            if (mem_req && mem_rdy) begin
                if (q_addr.size() == 0) begin
                    check(0, "R8", "unexpected request addr", mem_addr, 0);
                end else begin
                    check(mem_addr == q_addr[0], q_we[0] ? "R2" : "R4", "address",
                          mem_addr, q_addr[0]);
                    check(mem_we == q_we[0], "R2", "direction", mem_we, q_we[0]);
                    if (q_we[0])
                        check(mem_wdata == q_data[0], "R3", "write data",
                              mem_wdata, q_data[0]);
                    void'(q_addr.pop_front());
                    void'(q_we.pop_front());
                    void'(q_data.pop_front());
                end
                if (mem_we) begin
                    mem[mem_addr] = mem_wdata;
                end else begin
                    rsp_addr = mem_addr;
                    rsp_wait = (tick % 3 == 0) ? 2 : 1;
                end
            end
            if (done) begin
                done_cnt++;
                last_pass = pass;
                in_cmd = 0;
            end
        end
    end

    task automatic run(input bit f, input bit c, input bit [2:0] l, input bit d,
                       input bit [31:0] b0, input bit [31:0] b1,
                       input bit poke, input string req);
        bit exp_pass = 1;
        bit [31:0] bases[2];
        int start_cnt;
        bases[0] = b0 & ~32'h7;
        bases[1] = b1 & ~32'h7;
        if (f) begin
            for (int r = 0; r <= int'(d); r++)
                for (int k = 0; k < 80; k++) begin
                    q_addr.push_back(bases[r] + 32'(4 * k));
                    q_we.push_back(1'b1);
                    q_data.push_back(ref_pat(k / 2));
                end
        end else begin
            for (int r = 0; r <= int'(d) && exp_pass; r++)
                for (int j = 0; j < 40 && exp_pass; j++) begin
                    bit [31:0] a = bases[r] + 32'(8 * j) + (l[2] ? 32'd4 : 32'd0);
                    bit [31:0] got = mem.exists(a) ? mem[a] : 32'h0;
                    bit [31:0] want = ref_pat(j);
                    q_addr.push_back(a);
                    q_we.push_back(1'b0);
                    q_data.push_back(32'h0);
                    if (got[8*l[1:0] +: 8] != want[8*l[1:0] +: 8])
                        exp_pass = 0;
                end
        end
        @(negedge clk); #1;
        fill_go = f; check_go = c; lane = l; dual_rank = d;
        rank0_base = b0; rank1_base = b1;
        in_cmd = 1;
        start_cnt = done_cnt;
        @(negedge clk); #1;
        fill_go = 0; check_go = 0;
        if (poke) begin
            repeat (15) @(negedge clk);
            #1 fill_go = 1; check_go = 1;
            @(negedge clk); #1 fill_go = 0; check_go = 0;
        end
        while (done_cnt == start_cnt) @(negedge clk);
        repeat (4) @(negedge clk);
        check(done_cnt == start_cnt + 1, "R9", "done pulses", done_cnt - start_cnt, 1);
        check(q_addr.size() == 0, "R8", "requests left over", q_addr.size(), 0);
        check(last_pass == exp_pass, req, "pass", last_pass, exp_pass);
    endtask

    task automatic report();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst = 0;
        @(negedge clk);
        check(!busy && !done && !pass && !mem_req, "R1", "reset state",
              {busy, done, pass, mem_req}, 0);

        // R2 R3 R7: two-rank fill
        run(1, 0, 3'd0, 1, 32'h1000, 32'h2000, 0, "R2");
        // R4 R5 R6: every lane passes on clean data
        for (int l = 0; l < 8; l++)
            run(0, 1, 3'(l), 1, 32'h1000, 32'h2000, 0, "R6");
        // R8: corrupt byte 2 of upper half at rank1 entry 10
        mem[32'h2000 + 32'd84] = mem[32'h2000 + 32'd84] ^ 32'h00FF_0000;
        run(0, 1, 3'd6, 1, 32'h1000, 32'h2000, 0, "R8");
        run(0, 1, 3'd2, 1, 32'h1000, 32'h2000, 0, "R5");
        run(0, 1, 3'd7, 1, 32'h1000, 32'h2000, 0, "R5");
        // R8: mismatch on the final compared word of rank 0
        mem[32'h1000 + 32'd312] = mem[32'h1000 + 32'd312] ^ 32'h0000_0001;
        run(0, 1, 3'd0, 1, 32'h1000, 32'h2000, 0, "R8");
        run(0, 1, 3'd4, 1, 32'h1000, 32'h2000, 0, "R5");
        // R7: single rank check ignores rank 1 damage
        run(0, 1, 3'd6, 0, 32'h1000, 32'h2000, 0, "R7");
        // R9: starts during a busy fill are ignored
        run(1, 0, 3'd0, 1, 32'h1000, 32'h2000, 1, "R9");
        run(0, 1, 3'd6, 1, 32'h1000, 32'h2000, 1, "R9");
        // R10: low base bits dropped, single rank
        run(1, 0, 3'd0, 0, 32'h3005, 32'h0, 0, "R10");
        run(0, 1, 3'd5, 0, 32'h3007, 32'h0, 0, "R10");
        // R11: both starts together pick the fill
        run(1, 1, 3'd3, 1, 32'h4000, 32'h5000, 0, "R11");
        run(0, 1, 3'd3, 1, 32'h4000, 32'h5000, 0, "R11");
        report();
        $finish;
    end

endmodule